// File: doc/BRIEF.md
# BCD Calendar Clock with Held User Copy

The block keeps time of day and calendar date in packed BCD. A free-running base tick is divided by a prescaler into one-second steps, and each step moves the seconds forward. Carries pass on to minutes, hours, the day-of-week code, the date, the month and a two-digit year. These internal counters never stop.

Software reaches the clock through a small synchronous write port and a combinational read port. Reads return a user-visible copy of the counters, not the counters themselves. A transfer-enable bit in the control register decides whether that copy follows the counters. Software clears the bit to freeze a consistent snapshot while it reads the fields, then sets it again so that the copy catches up. Writing a time field sets the counter and its copy together and restarts the sub-second count, so the next one-second step comes a full second after the write.

Top module: `bcd_clock`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. A step from 59 returns the field to 00 and carries one into the next field. Seconds are at address 0 and minutes at address 1.
- R2: Hours count in BCD from 00 to 23 at address 2. The step from 23 returns hours to 00 and advances both the day-of-week code and the date.
- R3: One one-second step happens on each TICKS_PER_SEC-th cycle in which tick_i is high. While tick_i is low, the time does not move.
- R4: The day-of-week code at address 3 counts 1 to 7. It moves only at midnight, and from 7 it goes back to 1.
- R5: The date at address 4 runs from 01 to the length of the current month, then goes back to 01 and advances the month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by four and 28 days otherwise. Every other month has 31 days.
- R6: The month at address 5 counts 01 to 12. After 12 it goes back to 01 and advances the year at address 6. The year counts 00 to 99 and wraps to 00.
- R7: While the transfer-enable bit is 0, reads return the values frozen in the user copy, and the internal counters keep advancing.
- R8: While the transfer-enable bit is 1, each user-copy field takes the value its internal counter had one cycle earlier.
- R9: A write with we_i high to an address from 0 to 6 loads wdata_i into both that counter and its user copy at the next edge. The write also restarts the sub-second count, and no one-second step happens in the cycle of the write.
- R10: Address 7 is the control register, and bit 0 of it is transfer-enable. Reads of address 7 return 0 in bits 7 to 1. Reset sets transfer-enable to 1 and sets the time to 00:00:00, day code 1, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base tick enable that feeds the prescaler |
| we_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data: user copy or control register |

## Verification
A wrong counter or carry in the internal state does not show at the port right away. It reaches rdata_o one cycle later through the user copy while transfer-enable is 1. While the copy is frozen, it stays hidden until transfer-enable is set again. The reference model predicts the read value on every cycle, with the read address rotating across all eight registers, so a bad field shows within eight cycles of reaching the copy. The directed cases place the carry chain right at each month end, at a leap and a non-leap February, at the year wrap and at the day-code wrap. A skipped or doubled step therefore shows up as a date or code that differs from the model.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int ADDR_W     = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd7;
  localparam int F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_DOW = 3,
                 F_DATE = 4, F_MON = 5, F_YEAR = 6;

  typedef logic [7:0] bcd_t;
  typedef bcd_t [NUM_FIELDS-1:0] bank_t;

  function automatic bcd_t bcd_inc(bcd_t v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bcd_t field_min(int idx);
    return (idx == F_DOW || idx == F_DATE || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic bcd_t month_len(bcd_t mon, bcd_t yr);
    int y;
    y = 10 * int'(yr[7:4]) + int'(yr[3:0]);
    case (mon)
      8'h02:                      return (y % 4 == 0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd_t field_max(int idx, bcd_t mon, bcd_t yr);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_DOW:        return 8'h07;
      F_DATE:       return month_len(mon, yr);
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction
endpackage

// File: rtl/bcd_clock_prescale.sv
module bcd_clock_prescale #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic sec_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  assign sec_o = tick_i && (cnt_q == LAST) && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || sec_o)     cnt_q <= '0;
    else if (tick_i)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcd_clock_unit.sv
module bcd_clock_unit
  import bcd_clock_pkg::*;
#(
  parameter bcd_t MIN_VAL = 8'h00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic wrap_i,
  input  logic ld_i,
  input  bcd_t ld_val_i,
  output bcd_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= MIN_VAL;
    else if (ld_i)   q_o <= ld_val_i;
    else if (inc_i)  q_o <= wrap_i ? MIN_VAL : bcd_inc(q_o);
  end
endmodule

// File: rtl/bcd_clock_shadow.sv
module bcd_clock_shadow
  import bcd_clock_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  te_i,
  input  logic [NUM_FIELDS-1:0] ld_i,
  input  bcd_t                  ld_val_i,
  input  bank_t                 int_i,
  output bank_t                 usr_o
);
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       usr_o[i] <= field_min(i);
      else if (ld_i[i])  usr_o[i] <= ld_val_i;
      else if (te_i)     usr_o[i] <= int_i[i];
    end
  end
endmodule

// File: rtl/bcd_clock.sv
module bcd_clock
  import bcd_clock_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  bank_t                 int_q, usr_q, fmax;
  logic [NUM_FIELDS-1:0] ld, inc, wrap;
  logic                  time_wr, sec_pulse, te_q;

  assign time_wr = we_i && (addr_i != ADDR_CTRL);

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_ld
    assign ld[i] = we_i && (addr_i == ADDR_W'(i));
  end

  bcd_clock_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk_i, .rst_ni, .tick_i, .clr_i(time_wr), .sec_o(sec_pulse)
  );

  // carry chain: hour rollover feeds both day code and date
  assign inc[F_SEC]  = sec_pulse;
  assign inc[F_MIN]  = wrap[F_SEC];
  assign inc[F_HOUR] = wrap[F_MIN];
  assign inc[F_DOW]  = wrap[F_HOUR];
  assign inc[F_DATE] = wrap[F_HOUR];
  assign inc[F_MON]  = wrap[F_DATE];
  assign inc[F_YEAR] = wrap[F_MON];

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign fmax[i] = field_max(i, int_q[F_MON], int_q[F_YEAR]);
    assign wrap[i] = inc[i] && (int_q[i] >= fmax[i]);

    bcd_clock_unit #(.MIN_VAL(field_min(i))) u_unit (
      .clk_i, .rst_ni,
      .inc_i(inc[i]), .wrap_i(wrap[i]),
      .ld_i(ld[i]), .ld_val_i(wdata_i),
      .q_o(int_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          te_q <= 1'b1;
    else if (we_i && addr_i == ADDR_CTRL) te_q <= wdata_i[0];
  end

  bcd_clock_shadow u_shadow (
    .clk_i, .rst_ni, .te_i(te_q), .ld_i(ld), .ld_val_i(wdata_i),
    .int_i(int_q), .usr_o(usr_q)
  );

  always_comb begin
    rdata_o = {7'd0, te_q};
    for (int i = 0; i < NUM_FIELDS; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = usr_q[i];
  end
endmodule

// File: rtl/bcd_clock_chk.sv
module bcd_clock_chk
  import bcd_clock_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              te_q,
  input logic              sec_pulse,
  input bank_t             int_q,
  input bank_t             usr_q
);
  logic time_wr;
  assign time_wr = we_i && (addr_i != ADDR_CTRL);

  AST_SEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q[F_SEC] <= 8'h59 && int_q[F_SEC][3:0] <= 4'd9);                    // R1
  AST_HOUR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q[F_HOUR] <= 8'h23 && int_q[F_HOUR][3:0] <= 4'd9);                  // R2
  AST_SEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_pulse && !time_wr) |=> $stable(int_q[F_SEC]));                    // R3
  AST_DOW_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q[F_DOW] >= 8'h01 && int_q[F_DOW] <= 8'h07);                        // R4
  AST_DATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q[F_DATE] >= 8'h01 && int_q[F_DATE] <= 8'h31);                      // R5
  AST_MON_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q[F_MON] >= 8'h01 && int_q[F_MON] <= 8'h12);                        // R6
  AST_USER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!te_q && !we_i) |=> $stable(usr_q));                                   // R7
  AST_USER_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_q && !we_i) |=> usr_q == $past(int_q));                             // R8
  AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_wr |=> (int_q[$past(addr_i)] == $past(wdata_i) &&
                 usr_q[$past(addr_i)] == $past(wdata_i)));                  // R9
endmodule

bind bcd_clock bcd_clock_chk u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
  .te_q(te_q), .sec_pulse(sec_pulse), .int_q(int_q), .usr_q(usr_q)
);

// File: tb/bcd_clock_bench.sv
module bcd_clock_bench;
  localparam int TPS = 4;

  logic       clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, we_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'h00, rdata_o;

  int n_run = 0, n_fail = 0;
  string tag = "R10";
  bit done = 0;

  int m[7], u[7], pre, m_te;

  always #5 clk = ~clk;

  bcd_clock #(.TICKS_PER_SEC(TPS)) u_bcd_clock (
    .clk_i(clk), .rst_ni, .tick_i, .we_i, .addr_i, .wdata_i, .rdata_o
  );

  function automatic logic [7:0] to_bcd(int v);
    return 8'((v / 10) * 16 + v % 10);
  endfunction
  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    m = '{0, 0, 0, 1, 1, 1, 0};
    u = m;
    pre = 0;
    m_te = 1;
  endtask

  task automatic advance();
    m[0]++;
    if (m[0] < 60) return;
    m[0] = 0; m[1]++;
    if (m[1] < 60) return;
    m[1] = 0; m[2]++;
    if (m[2] < 24) return;
    m[2] = 0;
    m[3] = (m[3] == 7) ? 1 : m[3] + 1;
    m[4]++;
    if (m[4] <= mlen(m[5], m[6])) return;
    m[4] = 1; m[5]++;
    if (m[5] <= 12) return;
    m[5] = 1; m[6] = (m[6] + 1) % 100;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else begin
      int old[7];
      bit twr;
      old = m;
      twr = we_i && addr_i != 3'd7;
      for (int i = 0; i < 7; i++)
        if (twr && addr_i == 3'(i)) u[i] = from_bcd(wdata_i);
        else if (m_te != 0) u[i] = old[i];
      if (twr) begin
        m[addr_i] = from_bcd(wdata_i);
        pre = 0;
      end else if (tick_i) begin
        if (pre == TPS - 1) begin pre = 0; advance(); end
        else pre++;
      end
      if (we_i && addr_i == 3'd7) m_te = int'(wdata_i[0]);
    end
  end

  function automatic logic [7:0] expect_at(logic [2:0] a);
    return (a == 3'd7) ? {7'd0, m_te[0]} : to_bcd(u[a]);
  endfunction

  logic [2:0] rot = 3'd0;

  task automatic cyc(bit we, logic [2:0] a, logic [7:0] d, bit tk);
    @(negedge clk);
    if (rst_ni) begin
      n_run++;
      if (rdata_o !== expect_at(addr_i)) begin
        n_fail++;
        $display("FAIL %s addr %0d: got %h expected %h", tag, addr_i, rdata_o, expect_at(addr_i));
      end
    end
    we_i = we; addr_i = a; wdata_i = d; tick_i = tk;
  endtask

  task automatic run(int n, bit tk);
    for (int i = 0; i < n; i++) begin
      cyc(0, rot, 8'h00, tk);
      rot = rot + 3'd1;
    end
  endtask

  task automatic wr(logic [2:0] a, int v);
    cyc(1, a, (a == 3'd7) ? 8'(v) : to_bcd(v), 0);
  endtask

  task automatic set_time(int hr, int mi, int se, int dw, int dt, int mo, int yr);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
    wr(3'd3, dw); wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tag = "R10"; run(10, 0);                         // reset values and control register
    tag = "R3";  run(8, 0); run(24, 1);              // no move without tick, then 6 s
    tag = "R1";  set_time(10, 59, 57, 2, 5, 6, 30); run(32, 1);
    tag = "R2";  set_time(23, 59, 58, 3, 10, 5, 10); run(24, 1);
    tag = "R4";  set_time(23, 59, 59, 7, 11, 5, 10); run(16, 1);
    tag = "R5";  set_time(23, 59, 59, 1, 28, 2, 24); run(16, 1);  // leap
    set_time(23, 59, 59, 1, 29, 2, 24); run(16, 1);
    set_time(23, 59, 59, 1, 28, 2, 23); run(16, 1);                // non-leap
    set_time(23, 59, 59, 1, 30, 4, 23); run(16, 1);
    set_time(23, 59, 59, 1, 31, 1, 23); run(16, 1);
    tag = "R6";  set_time(23, 59, 59, 4, 31, 12, 99); run(16, 1);
    set_time(23, 59, 59, 4, 31, 12, 45); run(16, 1);
    tag = "R7";  wr(3'd7, 0); run(48, 1); run(8, 0);
    tag = "R8";  wr(3'd7, 1); run(24, 1);
    tag = "R9";  run(2, 1); wr(3'd0, 30); run(3, 1); wr(3'd1, 15); run(24, 1);
    wr(3'd7, 0); wr(3'd2, 7); run(16, 1); wr(3'd7, 1); run(8, 1);
    tag = "R1";  run(1000, 1);
    run(1, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule